// File: doc/BRIEF.md
# Reduced-Pin Receive Data Interface

This block sits between a receive symbol decoder and a reduced media-independent interface. The decoder delivers four-bit data nibbles with a valid strobe, together with a carrier-sense level and a false-carrier flag. The block holds the nibbles in a small FIFO and sends them toward the MAC as two-bit dibits, one per reference clock. A single line combines carrier sense and data valid.

Carrier sense goes up the cycle after carrier is seen. Data is held back until the FIFO is half full, and during that wait the data pins show a neutral `00`. After that, data flows without gaps. If carrier ends while nibbles are still buffered, the combined line alternates once per dibit, aligned to nibble boundaries, so the MAC can keep draining until the FIFO is empty. A false carrier shows a fixed `10` code for as long as the receive event lasts, and any data captured during it is thrown away.

Top module: `rmii_rx_path`

## Requirements
- R1: Out of reset, and whenever no receive event is in progress, `crs_dv` is 0 and `rxd` is `00`.
- R2: When `carrier_in` is sampled high while idle, `crs_dv` is 1 from the next clock, whether or not any nibble has arrived.
- R3: Until the FIFO holds `DEPTH/2` nibbles (8 with the default depth of 16), `rxd` is `00` while `crs_dv` is 1. The first data dibit appears on the clock after the edge at which that occupancy is registered.
- R4: Each nibble goes out as two consecutive dibits, `nib_data[1:0]` first and `nib_data[3:2]` second, with `crs_dv` at 1 throughout streaming. When nibbles arrive every two clocks, the dibit stream has no gaps.
- R5: When carrier drops during streaming, the nibble in flight completes. Each remaining nibble then goes out with `crs_dv` at 0 on its first dibit and 1 on its second. After the last one, the outputs return to the R1 state.
- R6: If carrier drops before the half-full point with at least one nibble buffered, draining as in R5 starts on the next clock, with no streaming phase.
- R7: When `false_carrier_in` is sampled high together with `carrier_in`, either while idle or while waiting for the FIFO to fill, `crs_dv` is 1 and `rxd` is `10` from the next clock until carrier drops. Nibbles received up to that point are discarded, so the next frame starts from an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| nib_valid | input | 1 | A decoded nibble is present on `nib_data` |
| nib_data | input | 4 | Decoded receive nibble |
| carrier_in | input | 1 | Carrier detected on the medium |
| false_carrier_in | input | 1 | Start delimiter was bad; receive event is a false carrier |
| crs_dv | output | 1 | Combined carrier sense and data valid |
| rxd | output | 2 | Receive dibit |

## Verification
The bench builds the block with a 16-nibble FIFO, which puts the streaming start at eight buffered nibbles. Frame lengths of 1, 4, 7, 8, 9 and 20 nibbles therefore land below, on, and above the point where carrier loss switches from a pure drain to streaming followed by a drain. The small depth also keeps each event short, so both false-carrier entry paths (from idle and from the fill wait) can be followed by a clean frame. That follow-up frame shows whether the discarded nibbles leaked through.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_STREAM,
        ST_DRAIN,
        ST_FALSE
    } rx_state_e;

    localparam logic [1:0] DIBIT_QUIET = 2'b00;
    localparam logic [1:0] DIBIT_BADSSD = 2'b10;

    typedef struct packed {
        logic       crs_dv;
        logic [1:0] rxd;
    } rmii_pins_t;

    function automatic logic [1:0] nib_dibit(input logic [3:0] nib, input logic upper);
        return upper ? nib[3:2] : nib[1:0];
    endfunction

endpackage

// File: rtl/rmii_rx_fifo.sv
module rmii_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             wr_ok, rd_ok;

    assign wr_ok   = wr_en && (count != FULL);
    assign rd_ok   = rd_en && (count != '0);
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(wr_ok) - CW'(rd_ok);
        end
    end
endmodule

// File: rtl/rmii_rx_ctrl.sv
module rmii_rx_ctrl
    import rmii_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            carrier,
    input  logic            false_carrier,
    input  logic            nib_valid,
    input  logic [CW-1:0]   fifo_count,
    output logic            push,
    output logic            pop,
    output logic            flush,
    output rx_state_e       state,
    output logic            phase
);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    rx_state_e     state_n;
    logic          phase_n;
    logic          moving, moving_n;
    logic [CW-1:0] cnt_after;

    assign moving    = (state == ST_STREAM) || (state == ST_DRAIN);
    assign moving_n  = (state_n == ST_STREAM) || (state_n == ST_DRAIN);
    assign push      = nib_valid && (fifo_count != FULL_C);
    assign pop       = moving && phase;
    assign flush     = (state == ST_FALSE);
    assign cnt_after = fifo_count + CW'(push) - CW'(pop);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (carrier) state_n = false_carrier ? ST_FALSE : ST_FILL;
            end
            ST_FILL: begin
                if (carrier && false_carrier)  state_n = ST_FALSE;
                else if (!carrier)             state_n = (cnt_after != '0) ? ST_DRAIN : ST_IDLE;
                else if (fifo_count >= HALF_C) state_n = ST_STREAM;
            end
            ST_STREAM: begin
                if (phase) begin
                    if (cnt_after == '0) state_n = carrier ? ST_FILL : ST_IDLE;
                    else if (!carrier)   state_n = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (phase && cnt_after == '0) state_n = ST_IDLE;
            end
            ST_FALSE: begin
                if (!carrier) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign phase_n = (moving && moving_n) ? ~phase : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            phase <= 1'b0;
        end else begin
            state <= state_n;
            phase <= phase_n;
        end
    end
endmodule

// File: rtl/rmii_rx_pinmux.sv
module rmii_rx_pinmux
    import rmii_rx_pkg::*;
(
    input  rx_state_e  state,
    input  logic       phase,
    input  logic [3:0] head,
    output rmii_pins_t pins
);
    always_comb begin
        pins = '{crs_dv: 1'b0, rxd: DIBIT_QUIET};
        unique case (state)
            ST_IDLE:   pins = '{crs_dv: 1'b0,  rxd: DIBIT_QUIET};
            ST_FILL:   pins = '{crs_dv: 1'b1,  rxd: DIBIT_QUIET};
            ST_STREAM: pins = '{crs_dv: 1'b1,  rxd: nib_dibit(head, phase)};
            ST_DRAIN:  pins = '{crs_dv: phase, rxd: nib_dibit(head, phase)};
            ST_FALSE:  pins = '{crs_dv: 1'b1,  rxd: DIBIT_BADSSD};
            default:   pins = '{crs_dv: 1'b0,  rxd: DIBIT_QUIET};
        endcase
    end
endmodule

// File: rtl/rmii_rx_path.sv
module rmii_rx_path
    import rmii_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       nib_valid,
    input  logic [3:0] nib_data,
    input  logic       carrier_in,
    input  logic       false_carrier_in,
    output logic       crs_dv,
    output logic [1:0] rxd
);
    localparam int CW = $clog2(DEPTH + 1);

    rx_state_e     state_w;
    logic          phase_w;
    logic          push_w, pop_w, flush_w;
    logic [CW-1:0] fifo_cnt;
    logic [3:0]    fifo_head;
    rmii_pins_t    pins_w;

    rmii_rx_fifo #(.DEPTH(DEPTH), .WIDTH(4), .CW(CW)) fifo_i (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush_w),
        .wr_en   (push_w),
        .wr_data (nib_data),
        .rd_en   (pop_w),
        .rd_data (fifo_head),
        .count   (fifo_cnt)
    );

    rmii_rx_ctrl #(.DEPTH(DEPTH), .CW(CW)) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .carrier       (carrier_in),
        .false_carrier (false_carrier_in),
        .nib_valid     (nib_valid),
        .fifo_count    (fifo_cnt),
        .push          (push_w),
        .pop           (pop_w),
        .flush         (flush_w),
        .state         (state_w),
        .phase         (phase_w)
    );

    rmii_rx_pinmux mux_i (
        .state (state_w),
        .phase (phase_w),
        .head  (fifo_head),
        .pins  (pins_w)
    );

    assign crs_dv = pins_w.crs_dv;
    assign rxd    = pins_w.rxd;
endmodule

// File: rtl/rmii_rx_checker.sv
module rmii_rx_checker
    import rmii_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          carrier,
    input logic          false_carrier,
    input logic          crs_dv,
    input logic [1:0]    rxd,
    input rx_state_e     st,
    input logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !carrier) |=> (!crs_dv && rxd == 2'b00));

    a_r2_crs_prompt: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && carrier) |=> crs_dv);

    a_r3_start_half: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STREAM && $past(st) == ST_FILL) |-> ($past(cnt) >= HALF_C));

    a_r3_fill_neutral: assert property (@(posedge clk) disable iff (rst)
        ($rose(crs_dv) && st == ST_FILL) |-> (rxd == 2'b00));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_C);

    a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STREAM || st == ST_DRAIN) |-> (cnt != '0));

    a_r5_drain_toggle: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN && !crs_dv) |=> crs_dv);

    a_r7_false_code: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && carrier && false_carrier) |=> (crs_dv && rxd == 2'b10));

    a_r7_false_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FALSE && carrier) |=> (crs_dv && rxd == 2'b10));
endmodule

bind rmii_rx_path rmii_rx_checker #(.DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .carrier       (carrier_in),
    .false_carrier (false_carrier_in),
    .crs_dv        (crs_dv),
    .rxd           (rxd),
    .st            (state_w),
    .cnt           (fifo_cnt)
);

// File: tb/rmii_rx_path_tb.sv
module rmii_rx_path_tb_top;

    localparam int TB_DEPTH = 16;
    localparam int HALF     = TB_DEPTH / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nib_valid = 1'b0;
    logic [3:0] nib_data = 4'h0;
    logic       carrier_in = 1'b0;
    logic       false_carrier_in = 1'b0;
    logic       crs_dv;
    logic [1:0] rxd;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rmii_rx_path #(.DEPTH(TB_DEPTH)) dut_i (
        .clk              (clk),
        .rst              (rst),
        .nib_valid        (nib_valid),
        .nib_data         (nib_data),
        .carrier_in       (carrier_in),
        .false_carrier_in (false_carrier_in),
        .crs_dv           (crs_dv),
        .rxd              (rxd)
    );

    task automatic chk(input string req, input int cyc, input logic e_crs, input logic [1:0] e_rxd);
        n_checks++;
        if (crs_dv !== e_crs || rxd !== e_rxd) begin
            n_fail++;
            $display("FAIL %s cycle %0d: crs_dv=%b rxd=%b expected crs_dv=%b rxd=%b",
                     req, cyc, crs_dv, rxd, e_crs, e_rxd);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            chk("R1", i, 1'b0, 2'b00);
            @(negedge clk);
        end
    endtask

    // One frame of n nibbles, one every two clocks; carrier covers 2n edges.
    task automatic run_frame(input int n, input int seed);
        logic [3:0] nibs [64];
        int ps;
        for (int i = 0; i < n; i++) nibs[i] = 4'((i * 11 + seed) ^ (i >> 1));
        ps = (n >= HALF) ? 2 * HALF : 2 * n + 1;
        for (int p = 0; p <= ps + 2 * n + 2; p++) begin
            if (p == 0) begin
                chk("R1", p, 1'b0, 2'b00);
            end else if (p < ps) begin
                chk((p == 1) ? "R2" : "R3", p, 1'b1, 2'b00);
            end else begin
                int k, j;
                k = p - ps;
                j = k / 2;
                if (j >= n) begin
                    chk("R1", p, 1'b0, 2'b00);
                end else if (j <= n - HALF) begin
                    chk("R4", p, 1'b1, (k % 2) ? nibs[j][3:2] : nibs[j][1:0]);
                end else begin
                    chk((n < HALF) ? "R6" : "R5", p, 1'((k % 2) != 0),
                        (k % 2) ? nibs[j][3:2] : nibs[j][1:0]);
                end
            end
            carrier_in = (p + 1 <= 2 * n);
            if (((p + 1) % 2 == 1) && (p / 2 < n)) begin
                nib_valid = 1'b1;
                nib_data  = nibs[p / 2];
            end else begin
                nib_valid = 1'b0;
                nib_data  = 4'h0;
            end
            @(negedge clk);
        end
        carrier_in = 1'b0;
        nib_valid  = 1'b0;
    endtask

    // False carrier flagged together with carrier while idle.
    task automatic false_from_idle();
        carrier_in = 1'b1;
        false_carrier_in = 1'b1;
        for (int p = 1; p <= 6; p++) begin
            nib_valid = 1'b1;
            nib_data  = 4'(p + 3);
            @(negedge clk);
            chk("R7", p, 1'b1, 2'b10);
        end
        carrier_in = 1'b0;
        false_carrier_in = 1'b0;
        nib_valid = 1'b0;
        @(negedge clk);
        chk("R7", 7, 1'b0, 2'b00);
    endtask

    // False carrier flagged after a few nibbles were buffered.
    task automatic false_from_fill();
        carrier_in = 1'b1;
        for (int p = 1; p <= 3; p++) begin
            nib_valid = (p % 2 == 1);
            nib_data  = 4'hC;
            @(negedge clk);
            chk("R3", p, 1'b1, 2'b00);
        end
        nib_valid = 1'b0;
        false_carrier_in = 1'b1;
        for (int p = 4; p <= 7; p++) begin
            @(negedge clk);
            chk("R7", p, 1'b1, 2'b10);
        end
        carrier_in = 1'b0;
        false_carrier_in = 1'b0;
        @(negedge clk);
        chk("R7", 8, 1'b0, 2'b00);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 0, 1'b0, 2'b00);
        rst = 1'b0;
        idle_cycles(3);
        run_frame(12, 3);
        idle_cycles(2);
        run_frame(4, 9);
        run_frame(HALF, 5);
        run_frame(HALF - 1, 1);
        run_frame(HALF + 1, 14);
        run_frame(1, 6);
        false_from_idle();
        run_frame(HALF + 2, 7);
        false_from_fill();
        run_frame(5, 2);
        run_frame(20, 11);
        idle_cycles(4);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule